// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache Controller

This block is a data cache placed between a processor load/store port and a slower word-wide main-memory port. The processor presents one word access at a time with a byte address and holds it until the controller raises `cpu_ready`. A hit finishes in the cycle it is presented. A miss stalls the processor while the controller fills the line. If the chosen line is dirty, it first writes the old line to memory and then reads the new one. Both transfers are 4-beat bursts.

Storage is 256 sets of two 16-byte lines, 8 KiB in all. Each line has a tag, a valid bit and a dirty bit. Each set has one recency bit that names the way to replace next. An empty way is always filled before a valid way is evicted.

A mode input selects the write policy at runtime:
- **Write-back:** write hits stay in the cache and mark the line dirty, and write misses allocate.
- **Write-through:** every write is sent to memory as one beat, hits also update the cached word, misses do not allocate, and no line ever becomes dirty.

Top module: `cache_2way_ctrl`

## Requirements
- R1: While reset is high and just after it, every valid, dirty and recency bit is clear, `cpu_ready` and `mem_valid` are low, and the first access to any address misses.
- R2: Bits [3:2] of the address pick the word, bits [11:4] pick the set, and bits [31:12] form the tag. A hit needs a valid way in the indexed set whose stored tag equals the address tag.
- R3: A miss reads the whole 16-byte-aligned line as exactly 4 read beats at byte offsets 0, 4, 8, 12 in that order.
- R4: A read hit, and a write hit in write-back mode, raise `cpu_ready` in the same cycle the request is presented, with no memory traffic.
- R5: On a miss, an invalid way is chosen first (way 0 before way 1).
- R6: Each set has one recency bit. Accessing way 0 sets it to 1 and accessing way 1 sets it to 0. When both ways are valid, the way it names is replaced.
- R7: In write-back mode a write hit updates only the cached word and marks the line dirty. Memory is not written.
- R8: Before a dirty line is replaced, its 4 words are written to memory as a write burst. Every write beat precedes the first read beat of the refill.
- R9: In write-through mode each write produces exactly one memory write beat, and `cpu_ready` rises in the cycle that beat is accepted. A hit also updates the cached word. A miss does not allocate. No line becomes dirty.
- R10: In write-back mode a write miss fills the line first, then writes the word into it.
- R11: During a miss `cpu_ready` stays low until the refill completes. A memory beat that is not accepted holds `mem_valid` and `mem_addr` steady.
- R12: Every read returns the value most recently written to that address, or the memory's initial content if it was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back; change only while idle |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Memory accepts the beat at this edge |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ready` |

## Verification
A hit is due in the same cycle as the request, so the bench drives each request just after a falling edge and samples `cpu_ready` 2 ns later, before the next rising edge. A fill ends one cycle after its fourth accepted read beat. A write-through write ends in the very cycle its single beat is accepted.

The bench counts falling edges until `cpu_ready` appears, with zero meaning a hit. It also counts read and write beats per access inside its memory model, which decides and records each beat at the falling edge before the accepting rising edge. A ready signal that toggles on alternate cycles makes every burst include refused beats.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } cc_state_e;
endpackage

// File: rtl/cc_tag_match.sv
module cc_tag_match #(
  parameter int TAG_W = 20
) (
  input  logic             valid,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] probe,
  output logic             hit
);
  assign hit = valid && (stored == probe);
endmodule

// File: rtl/cc_victim_pick.sv
module cc_victim_pick (
  input  logic valid0,
  input  logic valid1,
  input  logic lru_bit,
  output logic way
);
  // empty way first, way 0 ahead of way 1; recency bit only for a full set
  always_comb begin
    if (!valid0)      way = 1'b0;
    else if (!valid1) way = 1'b1;
    else              way = lru_bit;
  end
endmodule

// File: rtl/cc_data_array.sv
module cc_data_array #(
  parameter int DATA_W = 32,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/cache_2way_ctrl.sv
module cache_2way_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wt_mode,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int WAYS   = 2;
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = OFF_W - BOFF_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int DA_W   = 1 + IDX_W + WSEL_W;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = cpu_addr[OFF_W +: IDX_W];
  assign req_word = cpu_addr[BOFF_W +: WSEL_W];

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q   [WAYS];
  logic [SETS-1:0]  dirty_q [WAYS];
  logic [SETS-1:0]  lru_q;

  cc_state_e         st_q;
  logic [WSEL_W-1:0] beat_q;
  logic              vic_q;

  logic [WAYS-1:0] way_hit;
  logic            hit, hit_way, victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cc_tag_match #(.TAG_W(TAG_W)) u_match (
      .valid  (vld_q[w][req_idx]),
      .stored (tag_q[w][req_idx]),
      .probe  (req_tag),
      .hit    (way_hit[w])
    );
  end
  assign hit     = |way_hit;
  assign hit_way = way_hit[1];

  cc_victim_pick u_victim (
    .valid0  (vld_q[0][req_idx]),
    .valid1  (vld_q[1][req_idx]),
    .lru_bit (lru_q[req_idx]),
    .way     (victim)
  );

  logic              last_beat, fill_beat, fill_last, wt_write, idle_hit, wr_hit;
  logic              arr_we;
  logic [DA_W-1:0]   arr_waddr;
  logic [DATA_W-1:0] arr_wdata, rd_cpu, rd_evict;

  assign last_beat = (beat_q == {WSEL_W{1'b1}});
  assign fill_beat = (st_q == ST_FILL) && mem_ready;
  assign fill_last = fill_beat && last_beat;
  assign wt_write  = cpu_we && wt_mode;
  assign idle_hit  = (st_q == ST_IDLE) && cpu_req && hit;
  assign cpu_ready = (idle_hit && !wt_write) || ((st_q == ST_WTHRU) && mem_ready);
  assign wr_hit    = cpu_ready && hit && cpu_we;

  assign arr_we    = fill_beat || wr_hit;
  assign arr_waddr = fill_beat ? {vic_q, req_idx, beat_q} : {hit_way, req_idx, req_word};
  assign arr_wdata = fill_beat ? mem_rdata : cpu_wdata;

  cc_data_array #(.DATA_W(DATA_W), .AW(DA_W)) u_data (
    .clk     (clk),
    .we      (arr_we),
    .waddr   (arr_waddr),
    .wdata   (arr_wdata),
    .raddr_a ({hit_way, req_idx, req_word}),
    .rdata_a (rd_cpu),
    .raddr_b ({vic_q, req_idx, beat_q}),
    .rdata_b (rd_evict)
  );

  assign cpu_rdata = rd_cpu;
  assign mem_valid = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WBACK) || (st_q == ST_WTHRU);
  assign mem_wdata = (st_q == ST_WTHRU) ? cpu_wdata : rd_evict;

  always_comb begin
    case (st_q)
      ST_WBACK: mem_addr = {tag_q[vic_q][req_idx], req_idx, beat_q, {BOFF_W{1'b0}}};
      ST_FILL:  mem_addr = {req_tag, req_idx, beat_q, {BOFF_W{1'b0}}};
      default:  mem_addr = cpu_addr;
    endcase
  end

  // tag storage: written once per refill, no reset needed
  always_ff @(posedge clk) begin
    if (fill_last) tag_q[vic_q][req_idx] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      vic_q   <= 1'b0;
      lru_q   <= '0;
      for (int w = 0; w < WAYS; w++) begin
        vld_q[w]   <= '0;
        dirty_q[w] <= '0;
      end
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cpu_req) begin
            if (wt_write) begin
              st_q <= ST_WTHRU;
            end else if (!hit) begin
              vic_q  <= victim;
              beat_q <= '0;
              st_q   <= (vld_q[victim][req_idx] && dirty_q[victim][req_idx])
                        ? ST_WBACK : ST_FILL;
            end
          end
        end
        ST_WBACK: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st_q <= ST_IDLE;
          end
        end
        default: begin
          if (mem_ready) st_q <= ST_IDLE;
        end
      endcase

      if (cpu_ready && hit) lru_q[req_idx] <= ~hit_way;
      if (idle_hit && cpu_we && !wt_mode) dirty_q[hit_way][req_idx] <= 1'b1;
      if (fill_last) begin
        vld_q[vic_q][req_idx]   <= 1'b1;
        dirty_q[vic_q][req_idx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cc_checker.sv
module cc_checker
  import cc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int WSEL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wt_mode,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input cc_state_e         st,
  input logic [WSEL_W-1:0] beat,
  input logic [SETS-1:0]   vld0,
  input logic [SETS-1:0]   vld1,
  input logic [SETS-1:0]   dirty0,
  input logic [SETS-1:0]   dirty1,
  input logic [SETS-1:0]   lru
);
  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vld0 == '0 && vld1 == '0 && dirty0 == '0 && dirty1 == '0 && lru == '0));

  a_r11_beat_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r11_miss_stall: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WBACK || st == ST_FILL) |-> !cpu_ready);

  a_r8_evict_before_fill: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WBACK && mem_ready && beat == {WSEL_W{1'b1}}) |=> (st == ST_FILL));

  a_r9_no_new_dirty: assert property (@(posedge clk) disable iff (rst)
    wt_mode |=> ($countones({dirty1, dirty0}) <= $past($countones({dirty1, dirty0}))));
endmodule

bind cache_2way_ctrl cc_checker #(
  .ADDR_W (ADDR_W),
  .SETS   (SETS),
  .WSEL_W (WSEL_W)
) u_cc_checker (
  .clk       (clk),
  .rst       (rst),
  .wt_mode   (wt_mode),
  .cpu_ready (cpu_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .st        (st_q),
  .beat      (beat_q),
  .vld0      (vld_q[0]),
  .vld1      (vld_q[1]),
  .dirty0    (dirty_q[0]),
  .dirty1    (dirty_q[1]),
  .lru       (lru_q)
);

// File: tb/test_cache_2way_ctrl.sv
module test_cache_2way_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wt_mode = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  cache_2way_ctrl i_cache_2way_ctrl (
    .clk(clk), .rst(rst), .wt_mode(wt_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  int acc_rd = 0;
  int acc_wr = 0;
  bit stall_tog = 1'b0;
  bit [31:0] mm [int];   // main memory contents
  bit [31:0] rf [int];   // flat view every read must match

  function automatic bit [31:0] init_val(bit [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h1234_5678;
  endfunction
  function automatic bit [31:0] mm_rd(bit [31:0] a);
    return mm.exists(a) ? mm[a] : init_val(a);
  endfunction
  function automatic bit [31:0] rf_rd(bit [31:0] a);
    return rf.exists(a) ? rf[a] : init_val(a);
  endfunction

  task automatic chk(bit ok, string tag, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: decides each beat at the falling edge before the accepting rising edge
  always @(negedge clk) begin
    #1;
    if (mem_valid) begin
      stall_tog = ~stall_tog;
      mem_ready = stall_tog;
      if (stall_tog) begin
        if (mem_we) begin
          mm[mem_addr] = mem_wdata;
          acc_wr++;
          chk(acc_rd == 0, "R8 write beat after read beat", acc_rd, 0);
        end else begin
          mem_rdata = mm_rd(mem_addr);
          chk(mem_addr[3:0] == 4'((acc_rd % 4) * 4), "R3 burst order",
              {28'd0, mem_addr[3:0]}, (acc_rd % 4) * 4);
          acc_rd++;
        end
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic access(input bit we, input bit [31:0] a, input bit [31:0] d,
                        output bit [31:0] rd, output int cyc);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    acc_rd = 0; acc_wr = 0; cyc = 0;
    #2;
    while (!cpu_ready && cyc < 5000) begin
      @(negedge clk); #2; cyc++;
    end
    rd = cpu_rdata;
    if (we) rf[a] = d;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  // {we, addr, wdata, expect_hit, expect_write_beats}; set 5 tags 1/2/3, set 0 tag 7
  localparam logic [68:0] VEC [12] = '{
    {1'b0, 32'h0000_1050, 32'h0, 1'b0, 3'd0},        // cold miss, way 0 (R5)
    {1'b0, 32'h0000_1054, 32'h0, 1'b1, 3'd0},        // hit, same line
    {1'b1, 32'h0000_1058, 32'h1111_1111, 1'b1, 3'd0},// write-back hit, dirty (R7)
    {1'b0, 32'h0000_2050, 32'h0, 1'b0, 3'd0},        // miss into empty way 1 (R5)
    {1'b0, 32'h0000_1058, 32'h0, 1'b1, 3'd0},        // hit, way 0 most recent
    {1'b0, 32'h0000_3050, 32'h0, 1'b0, 3'd0},        // full set, replace way 1 (R6)
    {1'b0, 32'h0000_1050, 32'h0, 1'b1, 3'd0},        // way 0 survived (R6)
    {1'b0, 32'h0000_2050, 32'h0, 1'b0, 3'd0},        // replace way 1 again
    {1'b0, 32'h0000_3050, 32'h0, 1'b0, 3'd4},        // evict dirty way 0 (R8)
    {1'b0, 32'h0000_1058, 32'h0, 1'b0, 3'd0},        // refetch written word (R8)
    {1'b1, 32'h0000_7004, 32'h2222_2222, 1'b0, 3'd0},// write miss allocates (R10)
    {1'b0, 32'h0000_7004, 32'h0, 1'b1, 3'd0}         // now a hit (R10)
  };

  bit done = 1'b0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h0000_1050;
    #2;
    chk(cpu_ready == 1'b0, "R1 ready low in reset", cpu_ready, 0);
    chk(mem_valid == 1'b0, "R1 no memory request in reset", mem_valid, 0);
    @(negedge clk);
    cpu_req = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [68:0] v;
      v = VEC[i];
      access(v[68], v[67:36], v[35:4], rd, cyc);
      if (!v[68]) chk(rd == rf_rd(v[67:36]), "R12 R2 read data", rd, rf_rd(v[67:36]));
      chk((cyc == 0) == v[3], "R4 R5 R6 R1 hit or miss", cyc, v[3] ? 0 : 1);
      chk(acc_wr == int'(v[2:0]), "R7 R8 write beats", acc_wr, v[2:0]);
      chk(acc_rd == (v[3] ? 0 : 4), "R3 R11 read beats", acc_rd, v[3] ? 0 : 4);
      if (i == 2) chk(!mm.exists(32'h0000_1058), "R7 memory untouched by write hit", 1, 0);
      if (i == 8) chk(mm_rd(32'h0000_1058) == 32'h1111_1111, "R8 dirty data written back",
                      mm_rd(32'h0000_1058), 32'h1111_1111);
    end

    // write-through mode, switched while idle
    wt_mode = 1'b1;
    access(1'b1, 32'h0000_1058, 32'h3333_3333, rd, cyc);
    chk(acc_wr == 1 && acc_rd == 0, "R9 write-through hit is one write beat", acc_wr, 1);
    chk(mm_rd(32'h0000_1058) == 32'h3333_3333, "R9 memory updated at once",
        mm_rd(32'h0000_1058), 32'h3333_3333);
    access(1'b0, 32'h0000_1058, 32'h0, rd, cyc);
    chk(cyc == 0 && rd == 32'h3333_3333, "R9 cached word updated", rd, 32'h3333_3333);

    access(1'b1, 32'h0000_9000, 32'h4444_4444, rd, cyc);
    chk(acc_wr == 1 && acc_rd == 0, "R9 write-through miss is one write beat", acc_rd, 0);
    access(1'b0, 32'h0000_9000, 32'h0, rd, cyc);
    chk(acc_rd == 4, "R9 write miss did not allocate", acc_rd, 4);
    chk(rd == 32'h4444_4444, "R12 read after write-through", rd, 32'h4444_4444);

    access(1'b0, 32'h0000_4050, 32'h0, rd, cyc);
    chk(acc_wr == 0, "R6 evict clean way 0", acc_wr, 0);
    access(1'b0, 32'h0000_5050, 32'h0, rd, cyc);
    chk(acc_wr == 0, "R9 written line stayed clean", acc_wr, 0);
    chk(rd == rf_rd(32'h0000_5050), "R12 read data", rd, rf_rd(32'h0000_5050));
    access(1'b0, 32'h0000_105C, 32'h0, rd, cyc);
    chk(rd == rf_rd(32'h0000_105C), "R12 refetch after eviction", rd, rf_rd(32'h0000_105C));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule